// File: doc/BRIEF.md
# Glitch-Free Disable Gate for a Free-Running Pulse Stream

This block takes a free-running pulse stream, such as a divided oscillator signal, and passes it to a complementary output pair that can be switched off and on while the source keeps running. Switching happens only at safe points in the stream. A disable request waits for the stream's own falling edge. A release waits until the stream is low. As a result the gated output never carries a shortened high phase, and it never gains a pulse that the source did not produce. A downstream counter therefore sees only whole pulses.

The stream and the disable request arrive asynchronously. Each passes through a synchroniser of configurable depth onto a faster system clock. The gating decision runs on the synchronised level and on its detected falling edge. A one-bit gate state holds the decision between cycles. Alongside the gated pair, an ungated output always carries the inverted stream, whatever the disable input does. Reset is synchronous and active-high. It leaves the gate closed, with the true output low and the complement high.

Top module: `pulse_gate`

## Requirements
- R1: While the synchronised disable is low and the gate is open, `gate_q` equals the synchronised stream, 3 clock edges after `data_in` changes (two synchroniser flops and one output flop).
- R2: When the disable rises while the stream is high, `gate_q` stays high until that high phase ends and then falls together with the stream. Every high phase on `gate_q` is as long as the stream high phase it copies.
- R3: When the disable rises while the stream is low, the next rising edge of the stream does not reach `gate_q`, which stays low.
- R4: While the disable is held high after the gate has closed, `gate_q` stays low (1 = high) and `gate_qn` stays high.
- R5: `raw_qn` is always the inverse of the synchronised stream, with the same 3-edge latency, whether the disable is high or low.
- R6: While `rst` is high at a clock edge, the block enters the closed state. After that edge `gate_q` = 0, `gate_qn` = 1 and `raw_qn` = 1, and the synchroniser flops hold 0.
- R7: When the disable falls, the gate reopens only in a cycle where the synchronised stream is low. If the stream is high at that moment, the current high phase stays blocked, and the first pulse passed is a complete one.
- R8: `gate_qn` is always the inverse of `gate_q`.
- R9: With `data_in` held low, `gate_q` rests low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the pulse stream |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 1 | Asynchronous free-running pulse stream |
| hold_in | input | 1 | Asynchronous disable request, active high |
| gate_q | output | 1 | Gated stream, true polarity |
| gate_qn | output | 1 | Gated stream, complement |
| raw_qn | output | 1 | Ungated inverted stream |

## Verification
Every output is due exactly three rising clock edges after the input value that produced it is applied. Two of those edges belong to the synchroniser and one to the output register, and the disable request shares the same path. The driver stamps each expected item with the cycle number at which it falls due. The monitor wakes 1 ns after each rising edge and compares only the items whose stamp matches the current cycle. Separately, the monitor measures every high run on `gate_q` against the low run on `raw_qn` that ends in the same cycle, which checks pulse integrity. It also compares the total count of gated rising edges with the count the model expects.

// File: rtl/pg_pkg.sv
package pg_pkg;

    // Synchronised view of the two asynchronous inputs
    typedef struct packed {
        logic data;
        logic hold;
    } pg_in_t;

    localparam int PG_IN_W = $bits(pg_in_t);

    // Edge view of the synchronised stream
    typedef struct packed {
        logic level;
        logic fall;
    } pg_edge_t;

    // Registered outputs
    typedef struct packed {
        logic q;
        logic qn;
        logic raw_qn;
    } pg_out_t;

    localparam pg_out_t PG_OUT_RESET = '{q: 1'b0, qn: 1'b1, raw_qn: 1'b1};

    // Next value of the gate-closed bit.
    // Close when disabled and the stream has just fallen or is already low.
    // Reopen only when not disabled and the stream is low.
    // Otherwise (stream high) keep the current decision.
    function automatic logic pg_next_closed(logic cur, logic hold, pg_edge_t e);
        logic nxt;
        if (hold && (e.fall || !e.level))
            nxt = 1'b1;
        else if (!hold && !e.level)
            nxt = 1'b0;
        else
            nxt = cur;
        return nxt;
    endfunction

endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain[LAST];

endmodule

// File: rtl/pg_edge.sv
module pg_edge (
    input  logic             clk,
    input  logic             rst,
    input  logic             level_i,
    output pg_pkg::pg_edge_t edge_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level_i;
    end

    always_comb begin
        edge_o.level = level_i;
        edge_o.fall  = prev_q & ~level_i;
    end

endmodule

// File: rtl/pg_gate_core.sv
module pg_gate_core (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold_i,
    input  pg_pkg::pg_edge_t edge_i,
    output pg_pkg::pg_out_t  out_o,
    output logic             closed_o
);
    import pg_pkg::*;

    logic    closed_q;
    logic    closed_d;
    pg_out_t out_q;
    pg_out_t out_d;

    always_comb begin
        closed_d   = pg_next_closed(closed_q, hold_i, edge_i);
        out_d.q    = edge_i.level & ~closed_d;
        out_d.qn   = ~(edge_i.level & ~closed_d);
        out_d.raw_qn = ~edge_i.level;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            closed_q <= 1'b1;
            out_q    <= PG_OUT_RESET;
        end else begin
            closed_q <= closed_d;
            out_q    <= out_d;
        end
    end

    assign out_o    = out_q;
    assign closed_o = closed_q;

endmodule

// File: rtl/pulse_gate.sv
module pulse_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic data_in,
    input  logic hold_in,
    output logic gate_q,
    output logic gate_qn,
    output logic raw_qn
);
    import pg_pkg::*;

    pg_in_t   raw_in;
    pg_in_t   smp;
    pg_edge_t data_edge;
    pg_out_t  outs;
    logic     data_s;
    logic     hold_s;
    logic     gate_closed;

    assign raw_in.data = data_in;
    assign raw_in.hold = hold_in;

    pg_sync #(
        .WIDTH  (PG_IN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw_in),
        .sync_o  (smp)
    );

    assign data_s = smp.data;
    assign hold_s = smp.hold;

    pg_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (data_s),
        .edge_o  (data_edge)
    );

    pg_gate_core u_core (
        .clk      (clk),
        .rst      (rst),
        .hold_i   (hold_s),
        .edge_i   (data_edge),
        .out_o    (outs),
        .closed_o (gate_closed)
    );

    assign gate_q  = outs.q;
    assign gate_qn = outs.qn;
    assign raw_qn  = outs.raw_qn;

endmodule

// File: rtl/pulse_gate_checker.sv
module pulse_gate_checker (
    input logic clk,
    input logic rst,
    input logic gate_q,
    input logic gate_qn,
    input logic raw_qn,
    input logic data_s,
    input logic hold_s,
    input logic gate_closed
);
    logic rst_seen;

    always_ff @(posedge clk) rst_seen <= rst;

    // R6: after a reset edge the outputs sit in the closed state
    always @(negedge clk) begin
        if (rst_seen === 1'b1)
            assert_reset_state_R6: assert (gate_q == 1'b0 && gate_qn == 1'b1 && raw_qn == 1'b1);
    end

    assert_complement_R8: assert property (@(posedge clk) disable iff (rst)
        gate_qn == ~gate_q);

    assert_follow_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!hold_s && !gate_closed)) |-> gate_q == $past(data_s));

    assert_full_phase_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(gate_q)) |-> !$past(data_s));

    assert_swallow_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(hold_s && !data_s)) |-> gate_closed);

    assert_held_low_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(hold_s && gate_closed)) |-> !gate_q);

    assert_raw_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> raw_qn == ~$past(data_s));

    assert_release_low_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(gate_closed)) |-> !$past(data_s));

endmodule

bind pulse_gate pulse_gate_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .gate_q      (gate_q),
    .gate_qn     (gate_qn),
    .raw_qn      (raw_qn),
    .data_s      (data_s),
    .hold_s      (hold_s),
    .gate_closed (gate_closed)
);

// File: tb/sim_pulse_gate.sv
`timescale 1ns/1ps
module sim_pulse_gate;

    localparam int LAT = 3;

    typedef struct {
        int    due;
        bit    q;
        bit    raw;
        string tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic data_in = 1'b0;
    logic hold_in = 1'b0;
    logic gate_q, gate_qn, raw_qn;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;

    item_t exp_q[$];

    // model state
    bit m_closed = 1'b1;
    bit m_prev_q = 1'b0;
    int m_rises = 0;

    // monitor state
    bit p_gate = 1'b0;
    int d_rises = 0;
    int gl = 0;
    int rl = 0;
    int rl_done = 0;

    pulse_gate u0 (
        .clk     (clk),
        .rst     (rst),
        .data_in (data_in),
        .hold_in (hold_in),
        .gate_q  (gate_q),
        .gate_qn (gate_qn),
        .raw_qn  (raw_qn)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc = cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    // driver: apply one input pair and push the expected result
    task automatic step(input bit d, input bit h, input string tag);
        item_t it;
        @(negedge clk);
        data_in = d;
        hold_in = h;
        if (h && !d)       m_closed = 1'b1;
        else if (!h && !d) m_closed = 1'b0;
        it.due = cyc + LAT;
        it.q   = d & ~m_closed;
        it.raw = ~d;
        it.tag = tag;
        if (it.q && !m_prev_q) m_rises++;
        m_prev_q = it.q;
        exp_q.push_back(it);
    endtask

    task automatic pulse(input int hi, input int lo, input bit h, input string tag);
        for (int i = 0; i < hi; i++) step(1'b1, h, tag);
        for (int i = 0; i < lo; i++) step(1'b0, h, tag);
    endtask

    // monitor: compare due items, track pulse widths and rising edges
    always @(posedge clk) begin
        #1;
        if (mon_on) begin
            while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
                item_t it;
                it = exp_q.pop_front();
                chk(gate_q == it.q, it.tag, int'(gate_q), int'(it.q));
                chk(gate_qn == ~it.q, {it.tag, "/R8 gate_qn"}, int'(gate_qn), int'(~it.q));
                chk(raw_qn == it.raw, {it.tag, "/R5 raw_qn"}, int'(raw_qn), int'(it.raw));
            end
            if (!raw_qn) rl++;
            else begin
                if (rl != 0) rl_done = rl;
                rl = 0;
            end
            if (gate_q) gl++;
            else begin
                if (gl != 0) chk(gl == rl_done, "R2 gated high width vs input high phase", gl, rl_done);
                gl = 0;
            end
            if (gate_q && !p_gate) d_rises++;
            p_gate = gate_q;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R6: reset state
        chk(gate_q == 1'b0, "R6 gate_q in reset", int'(gate_q), 0);
        chk(gate_qn == 1'b1, "R6 gate_qn in reset", int'(gate_qn), 1);
        chk(raw_qn == 1'b1, "R6 raw_qn in reset", int'(raw_qn), 1);
        rst = 1'b0;
        mon_on = 1'b1;

        // R9: stream idle low, output rests low
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, "R9 idle low");

        // R1: pass-through with disable low, several widths
        pulse(3, 2, 1'b0, "R1 pass 3/2");
        pulse(5, 4, 1'b0, "R1 pass 5/4");
        pulse(1, 1, 1'b0, "R1 pass 1/1");
        pulse(2, 6, 1'b0, "R1 pass 2/6");

        // R2: disable rises mid high phase, pulse finishes
        step(1'b1, 1'b0, "R2 high before disable");
        step(1'b1, 1'b0, "R2 high before disable");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, "R2 high after disable");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R2 forced low");

        // R4: disable held, stream keeps running
        pulse(4, 3, 1'b1, "R4 held disabled");
        pulse(2, 2, 1'b1, "R4 held disabled");
        pulse(1, 5, 1'b1, "R4 held disabled");

        // R7: release while stream high, high phase stays blocked
        step(1'b1, 1'b1, "R7 high before release");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, "R7 released while high");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R7 reopen when low");
        pulse(4, 3, 1'b0, "R7 first full pulse");

        // R3: disable rises while low, next rise swallowed
        for (int i = 0; i < 2; i++) step(1'b0, 1'b1, "R3 disable while low");
        pulse(3, 3, 1'b1, "R3 swallowed rise");
        // release while low, pulses pass again
        for (int i = 0; i < 2; i++) step(1'b0, 1'b0, "R7 release while low");
        pulse(3, 2, 1'b0, "R1 pass after release");

        // disable pulse of one cycle while low
        step(1'b0, 1'b1, "R3 short disable");
        pulse(2, 2, 1'b0, "R7 after short disable");

        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, "R9 drain");
        repeat (LAT + 2) @(posedge clk);
        #2;
        chk(exp_q.size() == 0, "R1 all items compared", exp_q.size(), 0);
        chk(d_rises == m_rises, "R3 gated rising edge count", d_rises, m_rises);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule